// File: doc/BRIEF.md
# Virtual Address Hash Generator

This block takes a segment identifier, a 64-bit effective address, a segment-size select and a page shift. It builds the virtual page number, which is the virtual address counted in 4 KB units. From that number it then derives the index of an entry group in a hashed page table. Both the primary group and the secondary (alternate) group are produced, each under a table-size mask that the caller supplies. Searching the table and fetching its entries happen downstream, outside this block.

The block has two register stages. The first stage forms the page number and latches the size select, the page shift and the mask. The second stage applies the hash formula for the selected segment size. It then truncates the result, masks it and scales it into group indices. A valid flag travels through the two stages beside the data, so a new request can be accepted on every cycle.

When the page shift is below 12, the request is flagged as an error. The hash and both group indices are then driven to zero, while the page number is still formed.

Top module: `vahash_top`

## Requirements
- R1: With `segIs1T` = 0 (256 MB segment), `vpn` equals (segId << 16) | ((effAddr >> 12) & 0xFFFF), truncated to 64 bits.
- R2: With `segIs1T` = 1 (1 TB segment), `vpn` equals (segId << 28) | ((effAddr >> 12) & 0xFFFFFFF), truncated to 64 bits.
- R3: For a 256 MB segment and a page shift of at least 12, `hashOut` equals (vpn >> 16) XOR ((vpn & 0xFFFF) >> (pageShift − 12)).
- R4: For a 1 TB segment and a page shift of at least 12, with id = vpn >> 28, `hashOut` equals id XOR (id << 25) XOR ((vpn & 0xFFFFFFF) >> (pageShift − 12)).
- R5: `hashOut` keeps only the low 39 bits of the hash; any bit at position 39 or above is discarded.
- R6: `priGroup` equals (hashOut & tableMask) × 8, so its low three bits are always zero.
- R7: `secGroup` equals ((~hashOut) & tableMask) × 8.
- R8: A page shift below 12 sets `shiftErr` to 1 and drives `hashOut`, `priGroup` and `secGroup` to 0, while `vpn` still follows R1 or R2. A shift of 12 or more clears `shiftErr`.
- R9: The results for a request presented with `inValid` = 1 appear with `outValid` = 1 exactly two clock edges later. Requests on consecutive cycles produce results on consecutive cycles.
- R10: After reset all outputs are 0. When no request is accepted, the outputs hold their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; inputs are sampled when high |
| segId | input | 37 | Segment identifier |
| effAddr | input | 64 | Effective address |
| segIs1T | input | 1 | 0 selects a 256 MB segment, 1 selects a 1 TB segment |
| pageShift | input | 6 | Base-2 logarithm of the page size |
| tableMask | input | 39 | Table-size mask applied to the hash |
| outValid | output | 1 | Result strobe, two cycles after inValid |
| vpn | output | 64 | Virtual page number |
| hashOut | output | 39 | Truncated hash |
| priGroup | output | 42 | Primary group index (masked hash × 8) |
| secGroup | output | 42 | Secondary group index (masked complement × 8) |
| shiftErr | output | 1 | Page shift below 12 |

## Verification
Every result of a request (`vpn`, `hashOut`, both group indices and `shiftErr`) becomes visible together with `outValid` after the second rising edge following the cycle in which `inValid` was high. The bench drives inputs on falling edges and samples two falling edges after the request. For back-to-back requests it samples on the following falling edges, one per request. Hold behaviour is checked three cycles after the last request, after the inputs have changed with `inValid` low.

// File: rtl/vah_pkg.sv
package vah_pkg;
  typedef struct packed {
    logic loadFront;
    logic loadBack;
  } vah_strobe_t;

  localparam int PAGE_UNIT_SHIFT = 12;
  localparam int SEG_SHIFT_SMALL = 28;
  localparam int SEG_SHIFT_LARGE = 40;
  localparam int LARGE_ID_FOLD = 25;
endpackage

// File: rtl/vah_ctrl.sv
module vah_ctrl
  import vah_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output vah_strobe_t strobe,
  output logic        outValid
);
  logic frontValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      frontValid <= inValid;
      outValid   <= frontValid;
    end
  end

  always_comb begin
    strobe.loadFront = inValid;
    strobe.loadBack  = frontValid;
  end
endmodule

// File: rtl/vah_datapath.sv
module vah_datapath
  import vah_pkg::*;
#(
  parameter int ID_W     = 37,
  parameter int EA_W     = 64,
  parameter int VPN_W    = 64,
  parameter int HASH_W   = 39,
  parameter int SHIFT_W  = 6,
  parameter int GROUP_SZ = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  vah_strobe_t                   strobe,
  input  logic [ID_W-1:0]               segId,
  input  logic [EA_W-1:0]               effAddr,
  input  logic                          segIs1T,
  input  logic [SHIFT_W-1:0]            pageShift,
  input  logic [HASH_W-1:0]             tableMask,
  output logic [VPN_W-1:0]              vpn,
  output logic [HASH_W-1:0]             hashOut,
  output logic [HASH_W+$clog2(GROUP_SZ)-1:0] priGroup,
  output logic [HASH_W+$clog2(GROUP_SZ)-1:0] secGroup,
  output logic                          shiftErr
);
  localparam int GRP_BITS  = $clog2(GROUP_SZ);
  localparam int SMALL_LOW = SEG_SHIFT_SMALL - PAGE_UNIT_SHIFT;
  localparam int LARGE_LOW = SEG_SHIFT_LARGE - PAGE_UNIT_SHIFT;
  localparam logic [VPN_W-1:0] SMALL_MASK = (VPN_W'(1) << SMALL_LOW) - VPN_W'(1);
  localparam logic [VPN_W-1:0] LARGE_MASK = (VPN_W'(1) << LARGE_LOW) - VPN_W'(1);

  // front stage state
  logic [VPN_W-1:0]   vpnQ;
  logic               largeQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [HASH_W-1:0]  maskQ;
  logic               errQ;

  logic [VPN_W-1:0] idExt;
  logic [VPN_W-1:0] pageBits;
  logic [VPN_W-1:0] vpnNext;

  always_comb begin
    idExt    = VPN_W'(segId);
    pageBits = VPN_W'(effAddr >> PAGE_UNIT_SHIFT);
    if (segIs1T) vpnNext = (idExt << LARGE_LOW) | (pageBits & LARGE_MASK);
    else         vpnNext = (idExt << SMALL_LOW) | (pageBits & SMALL_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ   <= '0;
      largeQ <= 1'b0;
      shiftQ <= '0;
      maskQ  <= '0;
      errQ   <= 1'b0;
    end else if (strobe.loadFront) begin
      vpnQ   <= vpnNext;
      largeQ <= segIs1T;
      shiftQ <= pageShift;
      maskQ  <= tableMask;
      errQ   <= (pageShift < SHIFT_W'(PAGE_UNIT_SHIFT));
    end
  end

  // back stage combinational hash
  logic [SHIFT_W-1:0] dropAmt;
  logic [VPN_W-1:0]   smallHash;
  logic [VPN_W-1:0]   largeId;
  logic [VPN_W-1:0]   largeHash;
  logic [HASH_W-1:0]  hashNext;
  logic [HASH_W-1:0]  priMasked;
  logic [HASH_W-1:0]  secMasked;

  always_comb begin
    dropAmt   = shiftQ - SHIFT_W'(PAGE_UNIT_SHIFT);
    smallHash = (vpnQ >> SMALL_LOW) ^ ((vpnQ & SMALL_MASK) >> dropAmt);
    largeId   = vpnQ >> LARGE_LOW;
    largeHash = largeId ^ (largeId << LARGE_ID_FOLD) ^ ((vpnQ & LARGE_MASK) >> dropAmt);
    if (errQ)        hashNext = '0;
    else if (largeQ) hashNext = largeHash[HASH_W-1:0];
    else             hashNext = smallHash[HASH_W-1:0];
    priMasked = hashNext & maskQ;
    secMasked = errQ ? '0 : (~hashNext & maskQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpn      <= '0;
      hashOut  <= '0;
      priGroup <= '0;
      secGroup <= '0;
      shiftErr <= 1'b0;
    end else if (strobe.loadBack) begin
      vpn      <= vpnQ;
      hashOut  <= hashNext;
      priGroup <= {priMasked, {GRP_BITS{1'b0}}};
      secGroup <= {secMasked, {GRP_BITS{1'b0}}};
      shiftErr <= errQ;
    end
  end
endmodule

// File: rtl/vahash_top.sv
module vahash_top
  import vah_pkg::*;
#(
  parameter int ID_W     = 37,
  parameter int EA_W     = 64,
  parameter int VPN_W    = 64,
  parameter int HASH_W   = 39,
  parameter int SHIFT_W  = 6,
  parameter int GROUP_SZ = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [ID_W-1:0]       segId,
  input  logic [EA_W-1:0]       effAddr,
  input  logic                  segIs1T,
  input  logic [SHIFT_W-1:0]    pageShift,
  input  logic [HASH_W-1:0]     tableMask,
  output logic                  outValid,
  output logic [VPN_W-1:0]      vpn,
  output logic [HASH_W-1:0]     hashOut,
  output logic [HASH_W+$clog2(GROUP_SZ)-1:0] priGroup,
  output logic [HASH_W+$clog2(GROUP_SZ)-1:0] secGroup,
  output logic                  shiftErr
);
  vah_strobe_t strobe;

  vah_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  vah_datapath #(
    .ID_W(ID_W), .EA_W(EA_W), .VPN_W(VPN_W), .HASH_W(HASH_W),
    .SHIFT_W(SHIFT_W), .GROUP_SZ(GROUP_SZ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .segId(segId), .effAddr(effAddr), .segIs1T(segIs1T),
    .pageShift(pageShift), .tableMask(tableMask),
    .vpn(vpn), .hashOut(hashOut), .priGroup(priGroup),
    .secGroup(secGroup), .shiftErr(shiftErr)
  );
endmodule

// File: rtl/vahash_checker.sv
module vahash_checker #(
  parameter int HASH_W = 39,
  parameter int VPN_W  = 64,
  parameter int SHIFT_W = 6,
  parameter int GW     = 42
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [SHIFT_W-1:0] pageShift,
  input logic               outValid,
  input logic [VPN_W-1:0]   vpn,
  input logic [HASH_W-1:0]  hashOut,
  input logic [GW-1:0]      priGroup,
  input logic [GW-1:0]      secGroup,
  input logic               shiftErr
);
  logic prevIn, prevIn2, errIn, errIn2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= 1'b0; prevIn2 <= 1'b0; errIn <= 1'b0; errIn2 <= 1'b0;
    end else begin
      prevIn  <= inValid;
      prevIn2 <= prevIn;
      errIn   <= inValid && (pageShift < SHIFT_W'(12));
      errIn2  <= errIn;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid == prevIn2) else $error("latency");                          // R9
  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    shiftErr |-> (hashOut == '0 && priGroup == '0 && secGroup == '0))
    else $error("err zero");                                              // R8
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (shiftErr == errIn2)) else $error("err follows");        // R8
  AST_GROUP_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (priGroup[2:0] == 3'b0 && secGroup[2:0] == 3'b0))
    else $error("align");                                                 // R6
  AST_GROUPS_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((priGroup & secGroup) == '0)) else $error("disjoint");  // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !prevIn |=> ($stable(hashOut) && $stable(vpn) && $stable(priGroup)))
    else $error("hold");                                                  // R10
endmodule

bind vahash_top vahash_checker #(
  .HASH_W(HASH_W), .VPN_W(VPN_W), .SHIFT_W(SHIFT_W),
  .GW(HASH_W + $clog2(GROUP_SZ))
) u_vahash_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .pageShift(pageShift),
  .outValid(outValid), .vpn(vpn), .hashOut(hashOut),
  .priGroup(priGroup), .secGroup(secGroup), .shiftErr(shiftErr)
);

// File: tb/test_vahash_top.sv
`timescale 1ns/1ps
module test_vahash_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [36:0] segId;
  logic [63:0] effAddr;
  logic        segIs1T;
  logic [5:0]  pageShift;
  logic [38:0] tableMask;
  logic        outValid;
  logic [63:0] vpn;
  logic [38:0] hashOut;
  logic [41:0] priGroup;
  logic [41:0] secGroup;
  logic        shiftErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vahash_top i_vahash_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .segId(segId),
    .effAddr(effAddr), .segIs1T(segIs1T), .pageShift(pageShift),
    .tableMask(tableMask), .outValid(outValid), .vpn(vpn),
    .hashOut(hashOut), .priGroup(priGroup), .secGroup(secGroup),
    .shiftErr(shiftErr)
  );

  typedef struct packed {
    logic [36:0] id;
    logic [63:0] ea;
    logic        big;
    logic [5:0]  ps;
    logic [38:0] mask;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{37'h1,           64'h0,                   1'b0, 6'd12, 39'hFF},
    '{37'h12345ABCD,   64'hC000_0000_0ABC_D123, 1'b0, 6'd12, 39'h7FFFF},
    '{37'h1F_FFFF_FFFF,64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd16, 39'h7F_FFFF_FFFF},
    '{37'h0ABCDEF,     64'h0000_0123_4567_89AB, 1'b1, 6'd12, 39'hFFFFF},
    '{37'h1FFFFFFFF,   64'h00FF_FFFF_FFFF_F000, 1'b1, 6'd24, 39'h3FF},
    '{37'h5A5A5,       64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd40, 39'h7FFF},
    '{37'h0F0F0F0F0,   64'h1234_5678_9ABC_DEF0, 1'b0, 6'd28, 39'h1FFF}
  };

  function automatic logic [63:0] refVpn(vec_t v);
    logic [63:0] idw = 64'(v.id);
    if (v.big) return (idw << 28) | ((v.ea >> 12) & 64'hFFF_FFFF);
    return (idw << 16) | ((v.ea >> 12) & 64'hFFFF);
  endfunction

  function automatic logic [38:0] refHash(vec_t v);
    logic [63:0] p = refVpn(v);
    logic [63:0] h;
    logic [63:0] sid;
    if (v.ps < 6'd12) return 39'h0;
    if (v.big) begin
      sid = p >> 28;
      h = sid ^ (sid << 25) ^ ((p & 64'hFFF_FFFF) >> (v.ps - 6'd12));
    end else begin
      h = (p >> 16) ^ ((p & 64'hFFFF) >> (v.ps - 6'd12));
    end
    return h[38:0];
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic val);
    segId = v.id; effAddr = v.ea; segIs1T = v.big;
    pageShift = v.ps; tableMask = v.mask; inValid = val;
  endtask

  task automatic checkVec(string req, vec_t v);
    logic [38:0] h = refHash(v);
    chk(req, "outValid", 64'(outValid), 64'h1);
    chk(req, "vpn", vpn, refVpn(v));
    chk(req, "hash", 64'(hashOut), 64'(h));
    chk(req, "priGroup R6", 64'(priGroup), 64'({h & v.mask, 3'b000}));
    chk(req, "secGroup R7", 64'(secGroup),
        (v.ps < 6'd12) ? 64'h0 : 64'({~h & v.mask, 3'b000}));
    chk(req, "shiftErr", 64'(shiftErr), 64'(v.ps < 6'd12));
  endtask

  task automatic single(vec_t v);
    @(negedge clk); drive(v, 1'b1);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    rstN = 1'b0;
    drive(VECS[1], 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset outValid", 64'(outValid), 64'h0);
    chk("R10", "reset vpn", vpn, 64'h0);
    chk("R10", "reset hash", 64'(hashOut), 64'h0);
    chk("R10", "reset groups", 64'(priGroup | secGroup), 64'h0);
    rstN = 1'b1;

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      single(VECS[i]);
      checkVec(VECS[i].big ? "R2/R4" : "R1/R3", VECS[i]);
    end

    // hand values, R3 and R6 R7
    single(VECS[0]);
    chk("R3", "hand hash", 64'(hashOut), 64'h1);
    chk("R6", "hand pri", 64'(priGroup), 64'h8);
    chk("R7", "hand sec", 64'(secGroup), 64'h7F0);
    // R4 hand value
    v = '{37'h1, 64'h0, 1'b1, 6'd12, 39'h7F_FFFF_FFFF};
    single(v);
    chk("R4", "hand hash", 64'(hashOut), 64'h200_0001);
    // R5: fold bit lands at position 39 and is dropped
    v = '{37'h4000, 64'h0, 1'b1, 6'd12, 39'h7F_FFFF_FFFF};
    single(v);
    chk("R5", "truncated hash", 64'(hashOut), 64'h4000);
    chk("R2", "vpn 1T", vpn, 64'h400_0000_0000);

    // R8: shift below 12
    v = '{37'h12345, 64'hDEAD_BEEF_0000_1000, 1'b0, 6'd11, 39'h7F_FFFF_FFFF};
    single(v);
    checkVec("R8", v);
    v.ps = 6'd0; v.big = 1'b1;
    single(v);
    checkVec("R8", v);
    v.ps = 6'd12;
    single(v);
    chk("R8", "shift 12 clears err", 64'(shiftErr), 64'h0);

    // R9: back-to-back
    @(negedge clk); drive(VECS[3], 1'b1);
    @(negedge clk); drive(VECS[2], 1'b1);
    @(negedge clk); inValid = 1'b0;
    checkVec("R9", VECS[3]);
    @(negedge clk);
    checkVec("R9", VECS[2]);
    // R10: hold while idle
    drive(VECS[5], 1'b0);
    @(negedge clk);
    chk("R10", "idle outValid", 64'(outValid), 64'h0);
    repeat (2) @(negedge clk);
    chk("R10", "hold vpn", vpn, refVpn(VECS[2]));
    chk("R10", "hold hash", 64'(hashOut), 64'(refHash(VECS[2])));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule